// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a synthesizable behavioural model of the command front end of a word-wide NOR flash bank. It watches single-cycle bus writes (address, data, write strobe) and recognises three multi-write command sequences. The first is an unlock prefix followed by one word program. The second ends in a sector erase, and the third ends in a block erase. When a sequence completes, the block changes its small internal word array at once. It then raises a busy output for a fixed number of clock cycles, set separately for program and for erase. While the bank is busy, every write is dropped. Reads return a status word instead of array data: a polling bit and a toggle bit.

The array is a sampled subset of the 64K-word address space. It keeps 64 words, indexed by address bit 15 (the block), bits 12:11 (the low sector bits) and bits 2:0 (the word offset). Addresses that differ only in the other bits map to the same word. Reads are synchronous: a read strobe in one cycle updates the read data on the following clock edge. The read data holds when no read is requested.

Top module: `flash_cmd_front`

## Requirements
- R1: After synchronous active-low reset, busy is 0, read data is 0, every array word reads 16'hFFFF, and the decoder is idle.
- R2: The writes (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0) and then (A, D) program word A. Unlock addresses compare bits 14:0, and unlock data compares bits 7:0. Busy goes high on the edge that takes the fourth write and stays high for exactly PROG_CYCLES cycles.
- R3: A program only clears bits: the word becomes its old value AND D.
- R4: The writes (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55) and then (SA, 0x30) set every word whose address bits 15:11 equal those of SA to 16'hFFFF. Busy lasts exactly ERASE_CYCLES cycles.
- R5: The same prefix ending in (BA, 0x50) sets every word whose address bit 15 equals that of BA to 16'hFFFF. Words in the other block are unchanged.
- R6: A write whose address or data does not match the step it reaches sends the decoder back to idle, and the rest of that sequence has no effect.
- R7: Every write made while busy is 1 is discarded, including complete unlock and program sequences.
- R8: A read while busy returns a status word. Bit 7 is the inverse of bit 7 of the programmed data, or 0 during an erase. Bit 6 is the toggle bit. All other bits are 0.
- R9: The toggle bit reads 0 on the first busy read after an operation starts and inverts on each later busy read.
- R10: Once busy falls, reads return array data one cycle after the read strobe, and read data holds its value in cycles with no read.
- R11: A sixth erase write whose low data byte is neither 0x30 nor 0x50 starts nothing and returns the decoder to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 16 | Word address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data (array word or status) |
| busy | output | 1 | High while an internal program or erase runs |

## Verification
The bench counts the exact busy window after a program and after a sector erase. A timer that is off by one cycle, or that uses the wrong duration, shows up at either end of that window. It breaks an unlock sequence with a wrong data byte and ends an erase with an unknown code. A decoder that does not return to idle, or that accepts any final byte, would then change memory. It issues a full program sequence while busy, and programs a word twice to show that bits can only be cleared. It reads status several times in a row to catch a polling bit with the wrong polarity or a toggle bit that does not invert. Erases are checked against a neighbouring sector and the other block, so a wrong address decode would wipe words it should leave alone.

// File: rtl/flash_cmd_pkg.sv
// Shared types and command codes for the flash command front end.
// Assumes unlock addresses are compared on their low 15 bits and
// command data on its low byte.
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PGM,
        SQ_ERS3,
        SQ_ERS4,
        SQ_ERS5
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_BLK
    } op_kind_t;

    localparam int          UNL_AW    = 15;
    localparam logic [14:0] KEY_ADDR1 = 15'h5555;
    localparam logic [14:0] KEY_ADDR2 = 15'h2AAA;
    localparam logic [7:0]  KEY_DAT1  = 8'hAA;
    localparam logic [7:0]  KEY_DAT2  = 8'h55;
    localparam logic [7:0]  CMD_PROG  = 8'hA0;
    localparam logic [7:0]  CMD_ERASE = 8'h80;
    localparam logic [7:0]  CMD_SECT  = 8'h30;
    localparam logic [7:0]  CMD_BLK   = 8'h50;

endpackage

// File: rtl/flash_cmd_seq.sv
// Command sequence recogniser. Walks the unlock steps one write at a
// time and, on the write that completes a sequence, drives a one-cycle
// launch code in the same cycle (combinational). Writes while busy are
// dropped. Any mismatch returns the walk to idle.
module flash_cmd_seq
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [UNL_AW-1:0] key_addr,
    input  logic [7:0]        cmd_byte,
    output op_kind_t          launch_op
);

    seq_state_t state_q, state_d;
    logic       take, at_a1, at_a2;

    assign take  = wr_en && !busy;
    assign at_a1 = (key_addr == KEY_ADDR1);
    assign at_a2 = (key_addr == KEY_ADDR2);

    // Next-step selection and launch decode for the accepted write.
    always_comb begin
        state_d   = SQ_IDLE;
        launch_op = OP_NONE;
        case (state_q)
            SQ_IDLE: if (at_a1 && cmd_byte == KEY_DAT1) state_d = SQ_UNL1;
            SQ_UNL1: if (at_a2 && cmd_byte == KEY_DAT2) state_d = SQ_UNL2;
            SQ_UNL2: begin
                if (at_a1 && cmd_byte == CMD_PROG)  state_d = SQ_PGM;
                if (at_a1 && cmd_byte == CMD_ERASE) state_d = SQ_ERS3;
            end
            SQ_PGM:  if (take) launch_op = OP_PROG;
            SQ_ERS3: if (at_a1 && cmd_byte == KEY_DAT1) state_d = SQ_ERS4;
            SQ_ERS4: if (at_a2 && cmd_byte == KEY_DAT2) state_d = SQ_ERS5;
            SQ_ERS5: begin
                if (take && cmd_byte == CMD_SECT) launch_op = OP_SECT;
                if (take && cmd_byte == CMD_BLK)  launch_op = OP_BLK;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // Advance the walk only on writes accepted while idle-ready.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SQ_IDLE;
        else if (take)
            state_q <= state_d;
    end

endmodule

// File: rtl/flash_busy_timer.sv
// Busy interval counter. Loads the program or erase length on a start
// pulse and counts down; busy is high while the count is non-zero, so
// it lasts exactly the loaded number of cycles. Starts are assumed to
// arrive only while idle.
module flash_busy_timer #(
    parameter int PROG_CYCLES  = 1250,
    parameter int ERASE_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prog,
    input  logic start_erase,
    output logic busy
);

    localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_prog)
            cnt_q <= CNT_W'(PROG_CYCLES);
        else if (start_erase)
            cnt_q <= CNT_W'(ERASE_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/flash_word_array.sv
// Word storage. One register per word, reset to all ones (erased).
// The index is {block bits, kept sector bits, offset bits}. A program
// ANDs data into one word; a sector erase sets all words with matching
// block and sector fields; a block erase sets all with a matching block
// field. Read is combinational on the read index.
module flash_word_array
    import flash_cmd_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int BLK_W    = 1,
    parameter int SEC_KEEP = 2,
    parameter int OFS_BITS = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  op_kind_t                             op,
    input  logic [BLK_W+SEC_KEEP+OFS_BITS-1:0]   op_idx,
    input  logic [DATA_W-1:0]                    op_data,
    input  logic [BLK_W+SEC_KEEP+OFS_BITS-1:0]   rd_idx,
    output logic [DATA_W-1:0]                    rd_word
);

    localparam int IDX_W = BLK_W + SEC_KEEP + OFS_BITS;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam logic [IDX_W-1:0] MINE = IDX_W'(i);
        logic [DATA_W-1:0] word_q;
        logic              blk_hit, sec_hit;

        assign blk_hit = (op_idx[IDX_W-1 -: BLK_W] == MINE[IDX_W-1 -: BLK_W]);
        assign sec_hit = blk_hit &&
                         (op_idx[OFS_BITS +: SEC_KEEP] == MINE[OFS_BITS +: SEC_KEEP]);

        // Apply program or erase to this word when it is targeted.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '1;
            else if (op == OP_PROG && op_idx == MINE)
                word_q <= word_q & op_data;
            else if ((op == OP_SECT && sec_hit) || (op == OP_BLK && blk_hit))
                word_q <= '1;
        end

        assign words[i] = word_q;
    end

    assign rd_word = words[rd_idx];

endmodule

// File: rtl/flash_cmd_front.sv
// Top of the flash command front end. Joins the sequence recogniser,
// the busy timer and the word array, captures the polling/toggle
// status at launch and registers read data one cycle after rd_en.
// Assumes at most one write per cycle; reads while busy see status.
module flash_cmd_front
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 16,
    parameter int PROG_CYCLES  = 1250,
    parameter int ERASE_CYCLES = 3000,
    parameter int SECTOR_LSB   = 11,
    parameter int BLOCK_LSB    = 15,
    parameter int SEC_KEEP     = 2,
    parameter int OFS_BITS     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);

    localparam int BLK_W    = ADDR_W - BLOCK_LSB;
    localparam int IDX_W    = BLK_W + SEC_KEEP + OFS_BITS;
    localparam int BUSY_MAX = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;

    op_kind_t          launch_op;
    logic              launch_any;
    logic [IDX_W-1:0]  cur_idx;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] status_w;
    logic              poll_q, tog_q;

    assign cur_idx = {addr[ADDR_W-1:BLOCK_LSB],
                      addr[SECTOR_LSB+SEC_KEEP-1:SECTOR_LSB],
                      addr[OFS_BITS-1:0]};

    flash_cmd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .busy      (busy),
        .key_addr  (addr[UNL_AW-1:0]),
        .cmd_byte  (wdata[7:0]),
        .launch_op (launch_op)
    );

    assign launch_any = (launch_op != OP_NONE);

    flash_busy_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (launch_op == OP_PROG),
        .start_erase (launch_op == OP_SECT || launch_op == OP_BLK),
        .busy        (busy)
    );

    flash_word_array #(
        .DATA_W   (DATA_W),
        .BLK_W    (BLK_W),
        .SEC_KEEP (SEC_KEEP),
        .OFS_BITS (OFS_BITS)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (launch_op),
        .op_idx  (cur_idx),
        .op_data (wdata),
        .rd_idx  (cur_idx),
        .rd_word (rd_word)
    );

    // Capture polling bit at launch; flip toggle bit per busy read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_q <= 1'b0;
            tog_q  <= 1'b0;
        end else if (launch_any) begin
            poll_q <= (launch_op == OP_PROG) ? ~wdata[7] : 1'b0;
            tog_q  <= 1'b0;
        end else if (rd_en && busy) begin
            tog_q  <= ~tog_q;
        end
    end

    // Status word: polling bit at 7, toggle bit at 6, rest zero.
    always_comb begin
        status_w    = '0;
        status_w[7] = poll_q;
        status_w[6] = tog_q;
    end

    // Register read data: status while busy, array word otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= busy ? status_w : rd_word;
    end

endmodule

// File: rtl/flash_cmd_front_chk.sv
// Property checker for flash_cmd_front, attached by bind. Tracks the
// length of the current busy run with its own counter.
module flash_cmd_front_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic          busy,
    input logic [DW-1:0] rdata,
    input logic          launch_any,
    input logic          tog,
    input logic [31:0]   busy_limit
);

    logic [31:0] run_q;

    // Count consecutive busy cycles seen so far.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (busy)
            run_q <= run_q + 1;
        else
            run_q <= '0;
    end

    assert_launch_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch_any |=> busy);

    assert_no_launch_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !launch_any);

    assert_busy_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < busy_limit));

    assert_status_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rdata[DW-1:8] == '0 && rdata[5:0] == '0));

    assert_toggle_flips_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && !launch_any) |=> (tog != $past(tog)));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind flash_cmd_front flash_cmd_front_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .busy       (busy),
    .rdata      (rdata),
    .launch_any (launch_any),
    .tog        (tog_q),
    .busy_limit (32'(BUSY_MAX))
);

// File: tb/flash_cmd_front_tb.sv
module flash_cmd_front_tb;

    localparam int P = 40;
    localparam int E = 90;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    flash_cmd_front #(.PROG_CYCLES(P), .ERASE_CYCLES(E)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: pop expected read data after each read edge.
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk(rdata, 16'hxxxx, "scoreboard empty");
                end else begin
                    chk(rdata, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic program_word(input logic [15:0] a, input logic [15:0] d);
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
        wr(16'h5555, 16'h00A0);
        wr(a, d);
    endtask

    task automatic erase_prefix;
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
        wr(16'h5555, 16'h0080);
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
    endtask

    task automatic wait_idle;
        for (int n = 0; n < 1000 && busy; n++) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({15'd0, busy}, 16'd0, "R1 busy after reset");
        chk(rdata, 16'h0000, "R1 rdata after reset");
        rd(16'h0003, 16'hFFFF, "R1 erased word");
        rd(16'h8807, 16'hFFFF, "R1 erased word block1");

        // R2: program and exact busy window
        program_word(16'h0003, 16'h1234);
        chk({15'd0, busy}, 16'd1, "R2 busy at start");
        repeat (P - 1) @(negedge clk);
        chk({15'd0, busy}, 16'd1, "R2 busy last cycle");
        @(negedge clk);
        chk({15'd0, busy}, 16'd0, "R2 busy released");
        rd(16'h0003, 16'h1234, "R2 programmed word");

        // R3: second program only clears bits
        program_word(16'h0003, 16'hFF0F);
        wait_idle();
        rd(16'h0003, 16'h1204, "R3 and of old and new");

        // R8/R9: status reads during program (data bit7 = 0)
        program_word(16'h0802, 16'h0F0F);
        rd(16'h0802, 16'h0080, "R8 R9 first status");
        rd(16'h0802, 16'h00C0, "R9 second status");
        rd(16'h0802, 16'h0080, "R9 third status");
        wait_idle();
        rd(16'h0802, 16'h0F0F, "R10 data after busy");
        repeat (3) @(negedge clk);
        chk(rdata, 16'h0F0F, "R10 rdata holds");

        // R7: full sequence while busy is dropped
        program_word(16'h0005, 16'h0000);
        program_word(16'h0006, 16'h0000);
        wait_idle();
        rd(16'h0006, 16'hFFFF, "R7 write while busy ignored");
        rd(16'h0005, 16'h0000, "R7 first program applied");

        // R6: bad unlock data, then bad unlock address
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0054);
        wr(16'h5555, 16'h00A0);
        wr(16'h0007, 16'h0000);
        chk({15'd0, busy}, 16'd0, "R6 no launch after bad data");
        rd(16'h0007, 16'hFFFF, "R6 word untouched");
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAB, 16'h0055);
        wr(16'h5555, 16'h00A0);
        wr(16'h0007, 16'h0000);
        chk({15'd0, busy}, 16'd0, "R6 no launch after bad addr");
        rd(16'h0007, 16'hFFFF, "R6 word untouched 2");

        // R11: unknown final erase code
        erase_prefix();
        wr(16'h0000, 16'h0040);
        chk({15'd0, busy}, 16'd0, "R11 no launch");
        rd(16'h0003, 16'h1204, "R11 data kept");

        // R4: sector erase of sector 0, exact window
        erase_prefix();
        wr(16'h0000, 16'h0030);
        chk({15'd0, busy}, 16'd1, "R4 busy at start");
        repeat (E - 1) @(negedge clk);
        chk({15'd0, busy}, 16'd1, "R4 busy last cycle");
        @(negedge clk);
        chk({15'd0, busy}, 16'd0, "R4 busy released");
        rd(16'h0003, 16'hFFFF, "R4 sector word erased");
        rd(16'h0005, 16'hFFFF, "R4 sector word erased 2");
        rd(16'h0802, 16'h0F0F, "R4 next sector kept");

        // R5: block erase of block 0, status during erase
        program_word(16'h8001, 16'h00AA);
        wait_idle();
        erase_prefix();
        wr(16'h0000, 16'h0050);
        rd(16'h0802, 16'h0000, "R8 erase status poll bit");
        rd(16'h0802, 16'h0040, "R9 erase toggle");
        wait_idle();
        rd(16'h0802, 16'hFFFF, "R5 block word erased");
        rd(16'h8001, 16'h00AA, "R5 other block kept");

        repeat (3) @(negedge clk);
        chk(16'(exp_q.size()), 16'd0, "scoreboard drained");
        finish_run();
    end

endmodule